// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block is the receive side of a three-wire audio serial link made of a bit clock, a word clock and a data line. It turns the serial stream into 24-bit parallel samples. Each sample comes with a one-cycle valid strobe and a flag that marks it as the left or right channel. A three-bit format code picks one of three framings:
- left-justified, 24 bits;
- I2S, 24 bits;
- right-justified, 16, 18, 20 or 24 bits.

Right-justified words are sign-extended to 24 bits. Left-justified and I2S words are left-aligned.

All logic runs on a single reference clock. In slave mode the bit clock and the word clock are inputs, and they are sampled on that reference clock. In master mode the block divides the reference clock itself and drives out a 64 fS bit clock and a 50%-duty word clock. A two-bit select sets the reference clock to 128, 256 or 512 fS. The receiver then captures data on these internally generated clocks.

Top module: `audio_serial_rx`

## Requirements
- R1: Format codes 3'b010 and 3'b011 are invalid. While one of them is applied, `fmtErr` is 1, `sampleData` is zero and `sampleValid` stays low. Every other code keeps `fmtErr` at 0.
- R2: Code 3'b000 (left-justified) takes the MSB on the first rising bit-clock edge of a half-frame. Up to 24 bits are left-aligned into `sampleData`, and any bits not sent are zero. Word clock high marks the left channel.
- R3: Code 3'b001 (I2S) takes the MSB on the second rising bit-clock edge of a half-frame. Word clock low marks the left channel.
- R4: Codes 3'b100, 3'b101, 3'b110 and 3'b111 select right-justified words of 16, 18, 20 and 24 bits. The word's LSB is on the last rising bit-clock edge of the half-frame, and the output is sign-extended from the word's MSB to 24 bits.
- R5: Capture does not depend on the bit-clock rate, from 16 to 64 bit clocks per half-frame (32 fS to 128 fS).
- R6: Each completed half-frame gives exactly one `sampleValid` pulse, one cycle long. The pulse comes at the first rising bit-clock edge after the word clock changes. `sampleRight` is 1 for the right channel. A half-frame is only reported if a word-clock change came before it.
- R7: With `masterEn` high, `bclkOut` toggles at the reference clock divided by 2, 4 or 8 for `refRatio` 0, 1 and 2 or 3. That gives 64 bit clocks per `wclkOut` period. `wclkOut` has 50% duty and changes only while `bclkOut` is low.
- R8: With `masterEn` low, `bclkOut` and `wclkOut` are held low and the receiver runs from `bclkIn` and `wclkIn`.
- R9: In master mode, `sdIn` is captured on the generated clocks. A transmitter that follows `bclkOut` and `wclkOut` is therefore received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (128/256/512 fS in master mode) |
| rstN | input | 1 | Asynchronous reset, active low |
| masterEn | input | 1 | 1 = generate bit and word clocks, 0 = slave |
| refRatio | input | 2 | Reference-to-sample-rate ratio select: 0 = 128, 1 = 256, 2/3 = 512 |
| fmtCode | input | 3 | Data format code |
| bclkIn | input | 1 | Bit clock input (slave mode) |
| wclkIn | input | 1 | Word clock input (slave mode) |
| sdIn | input | 1 | Serial data |
| bclkOut | output | 1 | Generated bit clock (master mode, else low) |
| wclkOut | output | 1 | Generated word clock (master mode, else low) |
| sampleData | output | 24 | Received sample |
| sampleValid | output | 1 | One-cycle strobe per received sample |
| sampleRight | output | 1 | 1 = right channel, 0 = left channel |
| fmtErr | output | 1 | Invalid format code applied |

## Verification
Distinct left and right words are sent in every format. Swapping a channel or misplacing the MSB therefore shows up as a wrong value.

The right-justified widths are tested with negative words and a padded half-frame. This separates correct sign extension from capturing the wrong window. Left-justified is also run at 16 bit clocks per half-frame to check truncation, and right-justified 24-bit at 64 bit clocks per half-frame to check the count-back from the end.

In master mode, the clock periods and duty are measured at every ratio. A transmitter locked to the generated clocks then checks capture on those clocks.

// File: rtl/audrx_pkg.sv
package audrx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int POS_W = $clog2(SAMPLE_W);

  typedef enum logic [1:0] {
    FMT_LJ,
    FMT_I2S,
    FMT_RJ,
    FMT_BAD
  } fmtKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             shiftEn;
    logic             capWr;
    logic             capClear;
    logic [POS_W-1:0] capPos;
    logic             bitVal;
    logic             emit;
    logic             emitRight;
    logic             useShift;
    logic [1:0]       rjSel;
    logic             badFmt;
  } rxStrobe_t;
endpackage

// File: rtl/audio_rx_ctrl.sv
module audio_rx_ctrl
  import audrx_pkg::*;
#(
  parameter int HALF_CNT_W = 7,
  parameter int FRAME_LOG2 = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterEn,
  input  logic [1:0] refRatio,
  input  logic [2:0] fmtCode,
  input  logic       bclkIn,
  input  logic       wclkIn,
  input  logic       sdIn,
  output logic       bclkOut,
  output logic       wclkOut,
  output logic       fmtErr,
  output rxStrobe_t  stb
);
  localparam int REF_CNT_W = FRAME_LOG2 + 3;
  localparam logic [HALF_CNT_W-1:0] IDX_MAX = '1;

  fmtKind_e kind;
  logic [REF_CNT_W-1:0] refCnt;
  logic genB, genW, bclkOutQ, wclkOutQ;
  logic bclkQ, bclkPrev, wsQ, sdQ, wsLast, armed, fmtErrQ;
  logic rise, wsChange, inWin;
  logic [HALF_CNT_W-1:0] halfIdx, curIdx, offIdx, relIdx;

  always_comb begin
    unique case (fmtCode)
      3'b000:         kind = FMT_LJ;
      3'b001:         kind = FMT_I2S;
      3'b010, 3'b011: kind = FMT_BAD;
      default:        kind = FMT_RJ;
    endcase
  end

  // master clock division taps
  always_comb begin
    case (refRatio)
      2'd0:    begin genB = refCnt[0]; genW = refCnt[FRAME_LOG2];     end
      2'd1:    begin genB = refCnt[1]; genW = refCnt[FRAME_LOG2 + 1]; end
      default: begin genB = refCnt[2]; genW = refCnt[FRAME_LOG2 + 2]; end
    endcase
  end

  assign rise     = bclkQ & ~bclkPrev;
  assign wsChange = wsQ != wsLast;
  assign curIdx   = wsChange ? '0 : halfIdx;
  assign offIdx   = (kind == FMT_I2S) ? HALF_CNT_W'(1) : '0;
  assign relIdx   = curIdx - offIdx;
  assign inWin    = (curIdx >= offIdx) && (relIdx < HALF_CNT_W'(SAMPLE_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt   <= '0;
      bclkOutQ <= 1'b0;
      wclkOutQ <= 1'b0;
      bclkQ    <= 1'b0;
      bclkPrev <= 1'b0;
      wsQ      <= 1'b0;
      sdQ      <= 1'b0;
      wsLast   <= 1'b0;
      armed    <= 1'b0;
      halfIdx  <= '0;
      fmtErrQ  <= 1'b0;
    end else begin
      refCnt   <= masterEn ? refCnt + 1'b1 : '0;
      bclkOutQ <= masterEn & genB;
      wclkOutQ <= masterEn & genW;
      bclkQ    <= masterEn ? bclkOutQ : bclkIn;
      wsQ      <= masterEn ? wclkOutQ : wclkIn;
      sdQ      <= sdIn;
      bclkPrev <= bclkQ;
      fmtErrQ  <= (kind == FMT_BAD);
      if (rise) begin
        wsLast <= wsQ;
        armed  <= armed | wsChange;
        if (wsChange) halfIdx <= HALF_CNT_W'(1);
        else if (halfIdx != IDX_MAX) halfIdx <= halfIdx + 1'b1;
      end
    end
  end

  always_comb begin
    stb.shiftEn   = rise;
    stb.capWr     = rise & ((kind == FMT_LJ) | (kind == FMT_I2S)) & inWin;
    stb.capClear  = rise & wsChange;
    stb.capPos    = relIdx[POS_W-1:0];
    stb.bitVal    = sdQ;
    stb.emit      = rise & wsChange & armed & (kind != FMT_BAD);
    stb.emitRight = (kind == FMT_I2S) ? wsLast : ~wsLast;
    stb.useShift  = (kind == FMT_RJ);
    stb.rjSel     = fmtCode[1:0];
    stb.badFmt    = (kind == FMT_BAD);
  end

  assign bclkOut = bclkOutQ;
  assign wclkOut = wclkOutQ;
  assign fmtErr  = fmtErrQ;

  // R8: slave mode keeps generated clocks quiet
  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(masterEn) |-> (!bclkOut && !wclkOut));

  // R7: word clock moves only while the bit clock is low
  p_wclk_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(masterEn) && $past(masterEn, 2) && ($past(refRatio) == $past(refRatio, 2))
     && (wclkOut != $past(wclkOut))) |-> !bclkOut);
endmodule

// File: rtl/audio_rx_datapath.sv
module audio_rx_datapath
  import audrx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           stb,
  output logic [SAMPLE_W-1:0] sampleData,
  output logic                sampleValid,
  output logic                sampleRight
);
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] capReg, capNext, shReg, rjWord;
  int rjWidth;

  always_comb begin
    capNext = stb.capClear ? '0 : capReg;
    if (stb.capWr) capNext[TOP_POS - stb.capPos] = stb.bitVal;
  end

  always_comb begin
    case (stb.rjSel)
      2'd0:    rjWidth = 16;
      2'd1:    rjWidth = 18;
      2'd2:    rjWidth = 20;
      default: rjWidth = SAMPLE_W;
    endcase
    for (int i = 0; i < SAMPLE_W; i++)
      rjWord[i] = (i < rjWidth) ? shReg[i] : shReg[rjWidth-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg      <= '0;
      shReg       <= '0;
      sampleData  <= '0;
      sampleValid <= 1'b0;
      sampleRight <= 1'b0;
    end else begin
      capReg <= capNext;
      if (stb.shiftEn) shReg <= {shReg[SAMPLE_W-2:0], stb.bitVal};
      if (stb.badFmt) begin
        sampleData  <= '0;
        sampleValid <= 1'b0;
      end else begin
        sampleValid <= stb.emit;
        if (stb.emit) begin
          sampleData  <= stb.useShift ? rjWord : capReg;
          sampleRight <= stb.emitRight;
        end
      end
    end
  end

  // R6: valid is a single-cycle pulse
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R4: a 16-bit right-justified word fills the upper bits with its sign
  p_rj16_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && $past(stb.emit && stb.useShift && (stb.rjSel == 2'd0)))
    |-> (($countones(sampleData[SAMPLE_W-1:15]) == 0) ||
         ($countones(sampleData[SAMPLE_W-1:15]) == SAMPLE_W - 15)));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audrx_pkg::*;
#(
  parameter int HALF_CNT_W = 7,
  parameter int FRAME_LOG2 = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterEn,
  input  logic [1:0]          refRatio,
  input  logic [2:0]          fmtCode,
  input  logic                bclkIn,
  input  logic                wclkIn,
  input  logic                sdIn,
  output logic                bclkOut,
  output logic                wclkOut,
  output logic [SAMPLE_W-1:0] sampleData,
  output logic                sampleValid,
  output logic                sampleRight,
  output logic                fmtErr
);
  rxStrobe_t stb;

  audio_rx_ctrl #(.HALF_CNT_W(HALF_CNT_W), .FRAME_LOG2(FRAME_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .refRatio(refRatio),
    .fmtCode(fmtCode), .bclkIn(bclkIn), .wclkIn(wclkIn), .sdIn(sdIn),
    .bclkOut(bclkOut), .wclkOut(wclkOut), .fmtErr(fmtErr), .stb(stb)
  );

  audio_rx_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .sampleData(sampleData), .sampleValid(sampleValid), .sampleRight(sampleRight)
  );

  // R1: invalid format holds output at zero with no strobe
  p_err_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    fmtErr |-> ((sampleData == '0) && !sampleValid));
endmodule

// File: tb/sim_audio_serial_rx.sv
module sim_audio_serial_rx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterEn = 1'b0;
  logic [1:0] refRatio = 2'd0;
  logic [2:0] fmtCode = 3'b000;
  logic bclkIn = 1'b0, wclkIn = 1'b0, sdSlave = 1'b0, sdMaster = 1'b0, txOn = 1'b0;
  logic sdIn;
  logic bclkOut, wclkOut, sampleValid, sampleRight, fmtErr;
  logic [23:0] sampleData;

  int checks = 0, failures = 0, halfPer = 2;
  logic [23:0] logData [0:255];
  logic logRight [0:255];
  int logCnt = 0;
  logic [23:0] mL = 24'h000000, mR = 24'h000000;
  int mk = 0;
  logic mPrevW = 1'b0, mPrevB = 1'b0;

  assign sdIn = txOn ? sdMaster : sdSlave;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_rx u0 (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .refRatio(refRatio),
    .fmtCode(fmtCode), .bclkIn(bclkIn), .wclkIn(wclkIn), .sdIn(sdIn),
    .bclkOut(bclkOut), .wclkOut(wclkOut), .sampleData(sampleData),
    .sampleValid(sampleValid), .sampleRight(sampleRight), .fmtErr(fmtErr)
  );

  always @(negedge clk) begin
    if (sampleValid && logCnt < 256) begin
      logData[logCnt] = sampleData;
      logRight[logCnt] = sampleRight;
      logCnt++;
    end
  end

  // master-mode transmitter following the generated clocks
  always @(negedge clk) begin
    if (txOn) begin
      if (wclkOut != mPrevW) begin
        mk = 0;
        sdMaster = wclkOut ? mL[23] : mR[23];
      end else if (!bclkOut && mPrevB) begin
        mk++;
        sdMaster = (mk < 24) ? (wclkOut ? mL[23-mk] : mR[23-mk]) : 1'b0;
      end
    end
    mPrevW = wclkOut;
    mPrevB = bclkOut;
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    failures++;
    checks++;
    finishRun();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txBit(input logic ws, input logic b);
    bclkIn = 1'b0; wclkIn = ws; sdSlave = b;
    repeat (halfPer) @(negedge clk);
    bclkIn = 1'b1;
    repeat (halfPer) @(negedge clk);
    bclkIn = 1'b0;
  endtask

  // kind: 0 left-justified, 1 I2S, 2 right-justified
  task automatic sendHalf(input int kind, input logic ws, input logic [23:0] word, input int w, input int n);
    for (int k = 0; k < n; k++) begin
      logic b;
      b = 1'b0;
      if (kind == 0 && k < w) b = word[w-1-k];
      else if (kind == 1 && k >= 1 && k - 1 < w) b = word[w-k];
      else if (kind == 2 && (n - 1 - k) < w) b = word[n-1-k];
      txBit(ws, b);
    end
  endtask

  function automatic logic [23:0] expVal(input int kind, input logic [23:0] word, input int w, input int n);
    logic [23:0] e;
    e = '0;
    if (kind == 0) begin
      for (int k = 0; k < w && k < n; k++) e[23-k] = word[w-1-k];
    end else if (kind == 1) begin
      for (int k = 0; k < w && k < n - 1; k++) e[23-k] = word[w-1-k];
    end else begin
      for (int i = 0; i < 24; i++) e[i] = (i < w) ? word[i] : word[w-1];
    end
    return e;
  endfunction

  task automatic runSlave(input int kind, input logic leftWs, input logic [2:0] fmt, input int w, input int n,
                          input logic [23:0] l1, input logic [23:0] r1, input logic [23:0] l2,
                          input logic [23:0] r2, input string tag);
    int base;
    logic [23:0] exps [0:3];
    fmtCode = fmt;
    sendHalf(kind, ~leftWs, 24'h0, w, n);
    base = logCnt;
    sendHalf(kind, leftWs, l1, w, n);
    sendHalf(kind, ~leftWs, r1, w, n);
    sendHalf(kind, leftWs, l2, w, n);
    sendHalf(kind, ~leftWs, r2, w, n);
    sendHalf(kind, leftWs, 24'h0, w, n);
    repeat (8) @(negedge clk);
    exps[0] = expVal(kind, l1, w, n);
    exps[1] = expVal(kind, r1, w, n);
    exps[2] = expVal(kind, l2, w, n);
    exps[3] = expVal(kind, r2, w, n);
    chk(logCnt - base >= 4, {tag, " R6 sample count"}, 32'(logCnt - base), 32'd4);
    if (logCnt >= 4) begin
      for (int j = 0; j < 4; j++) begin
        chk(logData[logCnt-4+j] == exps[j], {tag, " data"}, {8'h0, logData[logCnt-4+j]}, {8'h0, exps[j]});
        chk(logRight[logCnt-4+j] == j[0], {tag, " R6 channel flag"}, 32'(logRight[logCnt-4+j]), 32'(j[0]));
      end
    end
    chk(!bclkOut && !wclkOut, {tag, " R8 slave clocks low"}, {30'h0, bclkOut, wclkOut}, 32'h0);
  endtask

  task automatic testFormats();
    halfPer = 2;
    runSlave(0, 1'b1, 3'b000, 24, 32, 24'hA5C33C, 24'h12F0E1, 24'h800001, 24'h7FFFFE, "R2 left-justified");
    runSlave(1, 1'b0, 3'b001, 24, 32, 24'hC0FFEE, 24'h0BADF0, 24'h955AA6, 24'h000001, "R3 I2S");
    runSlave(2, 1'b1, 3'b100, 16, 32, 24'h008001, 24'h007FFF, 24'h00F00F, 24'h000123, "R4 RJ16");
    runSlave(2, 1'b1, 3'b101, 18, 32, 24'h02ABCD, 24'h01FFFF, 24'h020000, 24'h00ABCD, "R4 RJ18");
    runSlave(2, 1'b1, 3'b110, 20, 32, 24'h0FEDCB, 24'h08ACE1, 24'h012345, 24'h0FFFFF, "R4 RJ20");
  endtask

  task automatic testRates();
    halfPer = 1;
    runSlave(2, 1'b1, 3'b111, 24, 64, 24'h9ABCDE, 24'h345678, 24'hFEDCBA, 24'h00FF00, "R5 R4 RJ24 at 128fS");
    halfPer = 3;
    runSlave(0, 1'b1, 3'b000, 24, 16, 24'hA5C33C, 24'h5A3CC3, 24'hFFFFFF, 24'h010203, "R5 R2 LJ at 32fS");
    halfPer = 2;
  endtask

  task automatic testBadFormat();
    int base;
    chk(sampleData != 24'h0, "R1 precondition nonzero data", {8'h0, sampleData}, 32'h1);
    fmtCode = 3'b010;
    repeat (3) @(negedge clk);
    chk(fmtErr == 1'b1, "R1 error flag on 010", 32'(fmtErr), 32'h1);
    chk(sampleData == 24'h0, "R1 data zero on 010", {8'h0, sampleData}, 32'h0);
    base = logCnt;
    sendHalf(0, 1'b1, 24'hFFFFFF, 24, 32);
    fmtCode = 3'b011;
    sendHalf(0, 1'b0, 24'hFFFFFF, 24, 32);
    sendHalf(0, 1'b1, 24'hFFFFFF, 24, 32);
    chk(logCnt == base, "R1 no strobe on invalid code", 32'(logCnt - base), 32'h0);
    chk(fmtErr == 1'b1 && sampleData == 24'h0, "R1 still zero on 011", {8'h0, sampleData}, 32'h0);
    fmtCode = 3'b000;
    repeat (3) @(negedge clk);
    chk(fmtErr == 1'b0, "R1 error flag clears", 32'(fmtErr), 32'h0);
  endtask

  task automatic measureMaster(input logic [1:0] ratio);
    int per, hi, br, expP;
    logic prevB, prevW;
    masterEn = 1'b1;
    refRatio = ratio;
    expP = (ratio == 2'd0) ? 128 : (ratio == 2'd1) ? 256 : 512;
    repeat (1100) @(negedge clk);
    prevW = wclkOut;
    while (!(wclkOut && !prevW)) begin
      prevW = wclkOut;
      @(negedge clk);
    end
    per = 0; hi = 0; br = 0; prevB = bclkOut; prevW = 1'b1;
    while (1) begin
      @(negedge clk);
      per++;
      if (wclkOut) hi++;
      if (bclkOut && !prevB) br++;
      prevB = bclkOut;
      if (wclkOut && !prevW) break;
      prevW = wclkOut;
      if (per > 2000) break;
    end
    chk(per == expP, "R7 word clock period", 32'(per), 32'(expP));
    chk(hi == expP / 2, "R7 word clock duty", 32'(hi), 32'(expP / 2));
    chk(br == 64, "R7 bit clocks per frame", 32'(br), 32'd64);
  endtask

  task automatic testMaster();
    for (int r = 0; r < 4; r++) measureMaster(2'(r));
    fmtCode = 3'b000;
    refRatio = 2'd1;
    mL = 24'h6B1D42;
    mR = 24'hD4E2B9;
    txOn = 1'b1;
    repeat (1800) @(negedge clk);
    chk(logCnt >= 2, "R9 master capture count", 32'(logCnt), 32'd2);
    if (logCnt >= 2) begin
      for (int j = 0; j < 2; j++) begin
        logic [23:0] e;
        e = logRight[logCnt-2+j] ? mR : mL;
        chk(logData[logCnt-2+j] == e, "R9 master capture data", {8'h0, logData[logCnt-2+j]}, {8'h0, e});
      end
      chk(logRight[logCnt-1] != logRight[logCnt-2], "R9 channels alternate", 32'(logRight[logCnt-1]), 32'(!logRight[logCnt-2]));
    end
    txOn = 1'b0;
    masterEn = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bclkOut && !wclkOut, "R8 clocks stop on return to slave", {30'h0, bclkOut, wclkOut}, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!sampleValid && sampleData == 24'h0, "reset data/valid", {7'h0, sampleValid, sampleData}, 32'h0);
    chk(!fmtErr && !bclkOut && !wclkOut, "reset flags R8", {29'h0, fmtErr, bclkOut, wclkOut}, 32'h0);
    testFormats();
    testRates();
    testBadFormat();
    testMaster();
    finishRun();
  end
endmodule